// File: doc/BRIEF.md
# Two-Level Table Walk Address Assist

This block sits beside the miss handler of a small memory-management unit and takes the bit-field arithmetic out of a software table walk. After a translation miss, software writes the faulting effective address into the block and reads back a pointer to the first-level descriptor. That pointer joins the upper bits of a programmed first-level table base with the directory index taken from the address. Software loads the descriptor from memory and writes it back into the block. Reading the walk register then returns the address of the second-level descriptor, already adjusted for the page size that the first-level descriptor encodes.

The first-level table always has 1024 descriptors, each covering 4 MiB, so the directory index is address bits [31:22]. Second-level tables hold 1024 descriptors of 4 bytes each, one for each 4 KiB page. A 16 KiB page fills four identical consecutive second-level slots, so ordinary 4 KiB indexing serves it. A 512 KiB page places its descriptors 128 bytes apart. An 8 MiB page has no second-level indexing: the first-level descriptor points straight at the page descriptor, and each such page takes two identical first-level slots. The block stores registers and does address arithmetic only. It issues no memory access and holds no translations.

Top module: `twa_assist`

## Requirements
- R1: While rst_n is low at a clock edge, all stored state clears, so every read select (0 base, 1 address, 2 walk, 3 pointer) returns zero after reset.
- R2: Read select 3 returns the first-level pointer. Bits [31:12] are base bits [31:12], and bits [11:0] are address bits [31:22] times 4. It follows the stored registers combinationally, so it is valid the cycle after either register is written.
- R3: Bits [11:0] of the programmed base have no effect on the pointer.
- R4: When a descriptor with bits 3 and 2 both clear is written to select 2, the walk result is the descriptor with bits [11:0] cleared, plus address bits [21:12] times 4.
- R5: When the descriptor has bit 2 (weight 0x4) set and bit 3 clear, the walk result is the descriptor with bits [11:0] cleared, plus address bits [21:19] times 128.
- R6: When the descriptor has bit 3 (weight 0x8) set, the walk result is the descriptor with bits [11:0] cleared, whatever bit 2 and the address hold.
- R7: The walk result is recomputed whenever select 1 or select 2 is written, using the newly written value, and is readable on select 2 in the next cycle. A write to the base leaves it unchanged.
- R8: A write to select 3 is ignored: base, address and walk readback all stay unchanged.
- R9: Reads of select 0 and select 1 return the full 32-bit value last written to the base and to the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Write target: 0 base, 1 address, 2 walk descriptor, 3 ignored |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 base, 1 address, 2 walk result, 3 first-level pointer |
| rd_data | output | 32 | Combinational read data |

## Verification
Every register captures its write on the rising edge where wr_valid is high. The pointer is a combinational function of the stored base and address, so it is due one edge after the write. The walk result is its own register, loaded on that same edge from the incoming write data, so it is also due one edge after a write to the address or the descriptor. The bench drives each write for one full cycle starting at a falling edge. It changes the read select and samples rd_data one nanosecond after the next falling edge, which is after that capture edge and clear of any edge.

// File: rtl/twa_pkg.sv
// Package: shared register-select encoding for the table walk assist.
// Assumes a two-bit select shared by the write and read ports.
package twa_pkg;
    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_EPN   = 2'd1,
        SEL_WALK  = 2'd2,
        SEL_L1PTR = 2'd3
    } twa_sel_e;
endpackage

// File: rtl/twa_regfile.sv
// Register storage for the base, the faulting address and the first-level
// descriptor. Besides the stored values it shows the values that will hold
// after the current edge, so the walk unit can load its result in the same
// cycle. Assumes one write per cycle; select 3 writes nothing.
module twa_regfile
    import twa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] base_q,
    output logic [W-1:0] epn_q,
    output logic [W-1:0] wc_q,
    output logic [W-1:0] epn_nx,
    output logic [W-1:0] wc_nx,
    output logic         walk_upd
);
    logic hit_base;
    logic hit_epn;
    logic hit_wc;

    // Decode the write target.
    always_comb begin
        hit_base = wr_valid && (twa_sel_e'(wr_sel) == SEL_BASE);
        hit_epn  = wr_valid && (twa_sel_e'(wr_sel) == SEL_EPN);
        hit_wc   = wr_valid && (twa_sel_e'(wr_sel) == SEL_WALK);
    end

    // Next-state values, used by the walk unit in the same cycle.
    always_comb begin
        epn_nx   = hit_epn ? wr_data : epn_q;
        wc_nx    = hit_wc  ? wr_data : wc_q;
        walk_upd = hit_epn || hit_wc;
    end

    // Store the three writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            epn_q  <= '0;
            wc_q   <= '0;
        end else begin
            if (hit_base) base_q <= wr_data;
            epn_q <= epn_nx;
            wc_q  <= wc_nx;
        end
    end
endmodule

// File: rtl/twa_l1_ptr.sv
// First-level pointer: the base with its in-page bits dropped, joined with
// the directory index scaled by the descriptor size. Purely combinational.
// Assumes the scaled index fits below PAGE_SHIFT.
module twa_l1_ptr #(
    parameter int W          = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int DIR_SHIFT  = 22,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] epn,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] PAGE_MASK = (W'(1) << PAGE_SHIFT) - W'(1);

    // Merge the table base with the scaled directory index.
    always_comb begin
        ptr = (base & ~PAGE_MASK) | ((epn >> DIR_SHIFT) << ENTRY_LOG2);
    end
endmodule

// File: rtl/twa_l2_unit.sv
// Second-level descriptor address. The page-size flags in the first-level
// descriptor pick the offset: an 8 MiB page adds none, a 512 KiB page uses
// a wide stride on the upper index bits, and every other size indexes per
// 4 KiB page. The result is registered and loaded when the address or the
// descriptor is written. Assumes the descriptor's pointer is page aligned.
module twa_l2_unit #(
    parameter int W            = 32,
    parameter int PAGE_SHIFT   = 12,
    parameter int DIR_SHIFT    = 22,
    parameter int ENTRY_LOG2   = 2,
    parameter int MID_SHIFT    = 19,
    parameter int MID_STR_LOG2 = 7,
    parameter int HUGE_BIT     = 3,
    parameter int LARGE_BIT    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] epn_nx,
    input  logic [W-1:0] entry_nx,
    output logic [W-1:0] l2_q
);
    localparam int SMALL_IDX_W = DIR_SHIFT - PAGE_SHIFT;
    localparam int MID_IDX_W   = DIR_SHIFT - MID_SHIFT;
    localparam logic [W-1:0] PAGE_MASK  = (W'(1) << PAGE_SHIFT) - W'(1);
    localparam logic [W-1:0] SMALL_MASK = (W'(1) << SMALL_IDX_W) - W'(1);
    localparam logic [W-1:0] MID_MASK   = (W'(1) << MID_IDX_W) - W'(1);

    logic [W-1:0] frame;
    logic [W-1:0] off_small;
    logic [W-1:0] off_mid;
    logic [W-1:0] l2_nx;

    // Form the table frame and both candidate offsets.
    always_comb begin
        frame     = entry_nx & ~PAGE_MASK;
        off_small = ((epn_nx >> PAGE_SHIFT) & SMALL_MASK) << ENTRY_LOG2;
        off_mid   = ((epn_nx >> MID_SHIFT) & MID_MASK) << MID_STR_LOG2;
    end

    // Pick the offset by page size; the huge flag takes priority.
    always_comb begin
        if (entry_nx[HUGE_BIT])       l2_nx = frame;
        else if (entry_nx[LARGE_BIT]) l2_nx = frame | off_mid;
        else                          l2_nx = frame | off_small;
    end

    // Hold the walk result until the next relevant write.
    always_ff @(posedge clk) begin
        if (!rst_n)    l2_q <= '0;
        else if (load) l2_q <= l2_nx;
    end
endmodule

// File: rtl/twa_assist.sv
// Top of the table walk address assist: register storage, first-level
// pointer, second-level walk unit and the combinational read multiplexer.
// Assumes software serialises the write, load, write-back and read steps.
module twa_assist
    import twa_pkg::*;
#(
    parameter int W            = 32,
    parameter int PAGE_SHIFT   = 12,
    parameter int DIR_SHIFT    = 22,
    parameter int ENTRY_LOG2   = 2,
    parameter int MID_SHIFT    = 19,
    parameter int MID_STR_LOG2 = 7,
    parameter int HUGE_BIT     = 3,
    parameter int LARGE_BIT    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] base_q;
    logic [W-1:0] epn_q;
    logic [W-1:0] wc_q;
    logic [W-1:0] epn_nx;
    logic [W-1:0] wc_nx;
    logic         walk_upd;
    logic [W-1:0] l1_ptr;
    logic [W-1:0] l2_q;

    twa_regfile #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .base_q   (base_q),
        .epn_q    (epn_q),
        .wc_q     (wc_q),
        .epn_nx   (epn_nx),
        .wc_nx    (wc_nx),
        .walk_upd (walk_upd)
    );

    twa_l1_ptr #(
        .W          (W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .DIR_SHIFT  (DIR_SHIFT),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_l1 (
        .base (base_q),
        .epn  (epn_q),
        .ptr  (l1_ptr)
    );

    twa_l2_unit #(
        .W            (W),
        .PAGE_SHIFT   (PAGE_SHIFT),
        .DIR_SHIFT    (DIR_SHIFT),
        .ENTRY_LOG2   (ENTRY_LOG2),
        .MID_SHIFT    (MID_SHIFT),
        .MID_STR_LOG2 (MID_STR_LOG2),
        .HUGE_BIT     (HUGE_BIT),
        .LARGE_BIT    (LARGE_BIT)
    ) u_l2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (walk_upd),
        .epn_nx   (epn_nx),
        .entry_nx (wc_nx),
        .l2_q     (l2_q)
    );

    // Select the read source.
    always_comb begin
        case (twa_sel_e'(rd_sel))
            SEL_BASE:  rd_data = base_q;
            SEL_EPN:   rd_data = epn_q;
            SEL_WALK:  rd_data = l2_q;
            default:   rd_data = l1_ptr;
        endcase
    end
endmodule

// File: rtl/twa_assist_chk.sv
// Checker for the table walk assist, bound into every instance of the top.
// Assumes the default geometry: 4 KiB frames, 128-byte wide stride.
module twa_assist_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_valid,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] base_q,
    input logic [W-1:0] epn_q,
    input logic [W-1:0] wc_q,
    input logic [W-1:0] l2_q,
    input logic [W-1:0] l1_ptr
);
    logic wr_walk;
    assign wr_walk = wr_valid && (wr_sel == 2'd2);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (base_q == '0 && epn_q == '0 && wc_q == '0 && l2_q == '0)); // R1

    AST_PTR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'd0) |=> (l1_ptr[W-1:12] == $past(wr_data[W-1:12]))); // R2

    AST_SMALL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_walk && !wr_data[3] && !wr_data[2])
        |=> (l2_q[1:0] == 2'b00 && l2_q[W-1:12] == $past(wr_data[W-1:12]))); // R4

    AST_MID_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_walk && !wr_data[3] && wr_data[2])
        |=> (l2_q[6:0] == 7'd0 && l2_q[11:10] == 2'd0
             && l2_q[W-1:12] == $past(wr_data[W-1:12]))); // R5

    AST_HUGE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_walk && wr_data[3])
        |=> (l2_q[11:0] == 12'd0 && l2_q[W-1:12] == $past(wr_data[W-1:12]))); // R6

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && (wr_sel == 2'd1 || wr_sel == 2'd2)) |=> $stable(l2_q)); // R7

    AST_SEL3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'd3)
        |=> ($stable(base_q) && $stable(epn_q) && $stable(wc_q))); // R8

    AST_EPN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'd1) |=> (epn_q == $past(wr_data))); // R9
endmodule

bind twa_assist twa_assist_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .base_q   (base_q),
    .epn_q    (epn_q),
    .wc_q     (wc_q),
    .l2_q     (l2_q),
    .l1_ptr   (l1_ptr)
);

// File: tb/twa_assist_test.sv
module twa_assist_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    twa_assist uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data)
    );

    always #5 clk = ~clk;

    // Vector: base, address, descriptor, expected pointer, expected walk.
    localparam int NV = 6;
    localparam logic [159:0] VEC [NV] = '{
        {32'h0012_3000, 32'hC040_5678, 32'h0ABC_D001, 32'h0012_3C04, 32'h0ABC_D014},
        {32'hFFFF_FABC, 32'h003F_F000, 32'h1234_5FF2, 32'hFFFF_F000, 32'h1234_5FFC},
        {32'h8000_0000, 32'h7FE8_0000, 32'h0055_5004, 32'h8000_07FC, 32'h0055_5280},
        {32'h0000_1000, 32'h0038_0000, 32'hFFFF_F0F4, 32'h0000_1000, 32'hFFFF_F380},
        {32'h0ABC_D000, 32'hFFFF_FFFF, 32'h0123_4FF8, 32'h0ABC_DFFC, 32'h0123_4000},
        {32'h0000_0000, 32'h1234_5678, 32'h0765_400C, 32'h0000_0120, 32'h0765_4000}
    };
    localparam string VTAG [NV] = '{"R4", "R3 R4", "R5", "R5", "R6", "R6"};

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_sel   = s;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk(input logic [1:0] s, input logic [31:0] exp, input string tag);
        rd_sel = s;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, s, rd_data, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) chk(2'(s), 32'h0, "R1 reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i][159:128]);
            wr(2'd1, VEC[i][127:96]);
            wr(2'd2, VEC[i][95:64]);
            chk(2'd3, VEC[i][63:32], {"R2 ", VTAG[i]});
            chk(2'd2, VEC[i][31:0],  VTAG[i]);
            chk(2'd0, VEC[i][159:128], "R9 base");
            chk(2'd1, VEC[i][127:96],  "R9 epn");
        end

        // R7: descriptor write recomputes with the held address.
        wr(2'd2, 32'h0000_2000);
        chk(2'd2, 32'h0000_2D14, "R7 walk write");
        // R7: address write recomputes with the held descriptor.
        wr(2'd1, 32'h0000_1000);
        chk(2'd2, 32'h0000_2004, "R7 epn write");
        // R7: base write leaves the walk result alone.
        wr(2'd0, 32'hAAAA_A000);
        chk(2'd2, 32'h0000_2004, "R7 base write");
        chk(2'd3, 32'hAAAA_A000, "R2 new base");

        // R8: writes to the pointer select are ignored.
        wr(2'd3, 32'hFFFF_FFFF);
        chk(2'd0, 32'hAAAA_A000, "R8 base");
        chk(2'd1, 32'h0000_1000, "R8 epn");
        chk(2'd2, 32'h0000_2004, "R8 walk");
        chk(2'd3, 32'hAAAA_A000, "R8 ptr");

        // R1: reset in mid-use clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) chk(2'(s), 32'h0, "R1 mid reset");
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule